// File: doc/BRIEF.md
# Dual-Channel Serial Audio Converter Transmitter

This block feeds a dual 18-bit serial-input audio converter from one system clock. Upstream logic hands over a left/right sample pair through a valid/ready handshake. The block sends both words at the same time on two separate serial data lines, one line per channel. There is no left/right select clock. The block also produces a bit clock and a word clock. The converter takes in one bit on each rising bit-clock edge, and it transfers the whole word to its output on the falling edge of the word clock.

The length of one word period in system-clock cycles comes from a ratio input. The ratio is first clamped to the range the converter accepts. In strict mode it is then rounded down to a multiple of the strict step. Each bit clock period lasts two system-clock cycles, so the 18 data bits use the first 36 cycles of each word period, and the bit clock is idle for the rest of it. A new period starts as soon as the previous one ends. If no pair is waiting at that point, the previous pair is sent again and a sticky underrun flag is set. At a word rate of 352.8 kHz, the default upper limit of 384 cycles per word needs a system clock of about 135 MHz.

Top module: `dac_serial_tx`

## Requirements
- R1: While reset is asserted: `bck` = 0, `wdck` = 1, `sd_left` = `sd_right` = 0, `underrun` = 0 and `s_ready` = 1.
- R2: After reset and before the first pair is accepted, the outputs keep their R1 values and no word-clock edge occurs.
- R3: Each word period holds exactly 18 bit-clock pulses, each one cycle high and one cycle low. All of them fall while `wdck` is high, and `bck` stays low after the 18th.
- R4: Each channel word is 18-bit two's complement sent MSB first (bit 17 first). A data line changes only while `bck` is low, and the converter captures it on the rising `bck` edge.
- R5: `s_left` is sent on `sd_left` and `s_right` on `sd_right`, both within the same word period.
- R6: `wdck` is high for the first 36 cycles of each period and low for the remaining cycles. It falls in the cycle right after the 18th `bck` high cycle.
- R7: With `strict_mode` = 0, the word period in cycles equals `ratio_req` clamped to [48, 384].
- R8: With `strict_mode` = 1, the clamped ratio is rounded down to a multiple of 24 (for example 100 gives 96, 383 gives 360, 30 gives 48).
- R9: The ratio is sampled only when a period starts. A change in the middle of a period takes effect from the next period on.
- R10: `s_ready` is high while idle and during the last cycle of each period, and low otherwise. A pair is taken at a clock edge where `s_valid` and `s_ready` are both high, and the period it starts begins in the next cycle.
- R11: If `s_valid` is low in the last cycle of a period, the previous pair is sent again and `underrun` goes high and stays high until reset. While pairs arrive in time, `underrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ratio_req | input | 9 | Requested system-clock cycles per word period |
| strict_mode | input | 1 | 1 rounds the ratio down to a multiple of 24 |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Block can take a pair at this edge |
| s_left | input | 18 | Left sample, two's complement |
| s_right | input | 18 | Right sample, two's complement |
| bck | output | 1 | Bit clock |
| wdck | output | 1 | Word clock; its falling edge loads the converter |
| sd_left | output | 1 | Left serial data |
| sd_right | output | 1 | Right serial data |
| underrun | output | 1 | Sticky flag: a pair was sent again |

## Verification
The bench builds the block with its default parameters: 18-bit words, ratio limits 48 and 384, and a strict step of 24. With these values both clamp limits and the strict rounding can be reached through `ratio_req` alone, and even a 384-cycle period completes in a few hundred cycles. A port-level monitor rebuilds each word from the `bck` rising edges, counts the pulses, and measures the word-clock high time and the spacing between `wdck` falls. It does this for streamed pairs, for a mid-period ratio change and for repeated pairs.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // largest multiple of step that does not exceed v
  function automatic int unsigned floor_step(input int unsigned v, input int unsigned step);
    return v - (v % step);
  endfunction

endpackage

// File: rtl/dac_ratio_sel.sv
module dac_ratio_sel #(
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned MIN_RATIO = 48,
  parameter int unsigned MAX_RATIO = 384,
  parameter int unsigned STEP      = 24
) (
  input  logic [CNT_W-1:0] ratio_req,
  input  logic             strict,
  output logic [CNT_W-1:0] ratio_eff
);
  import dac_tx_pkg::*;

  logic [CNT_W-1:0] clamped;

  always_comb begin
    if (ratio_req < CNT_W'(MIN_RATIO)) begin
      clamped = CNT_W'(MIN_RATIO);
    end else if (ratio_req > CNT_W'(MAX_RATIO)) begin
      clamped = CNT_W'(MAX_RATIO);
    end else begin
      clamped = ratio_req;
    end
    if (strict) begin
      ratio_eff = CNT_W'(floor_step(32'(clamped), STEP));
    end else begin
      ratio_eff = clamped;
    end
  end

endmodule

// File: rtl/dac_frame_timer.sv
module dac_frame_timer #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned CNT_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ratio_eff,
  input  logic             in_valid,
  output logic             ready_o,
  output logic             take_o,
  output logic             repeat_o,
  output logic             shift_o,
  output logic             bck_o,
  output logic             wdck_o
);
  import dac_tx_pkg::*;

  localparam int unsigned BIT_CYC = 2 * WORD_W;

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             bck_q, bck_d;
  logic             wdck_q, wdck_d;
  logic             boundary, start, run_d, in_bits;

  // next-state
  always_comb begin
    boundary = (phase_q == PH_RUN) && (cnt_q == last_q);
    ready_o  = (phase_q == PH_IDLE) || boundary;
    take_o   = ready_o && in_valid;
    repeat_o = boundary && !in_valid;
    start    = take_o || repeat_o;
    shift_o  = (phase_q == PH_RUN) && cnt_q[0] && (cnt_q < CNT_W'(BIT_CYC));

    phase_d  = start ? PH_RUN : phase_q;
    if (start) begin
      cnt_d = '0;
    end else if (phase_q == PH_RUN) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
    last_d   = start ? (ratio_eff - CNT_W'(1)) : last_q;

    run_d    = (phase_d == PH_RUN);
    in_bits  = cnt_d < CNT_W'(BIT_CYC);
    bck_d    = run_d && in_bits && cnt_d[0];
    wdck_d   = !run_d || in_bits;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      bck_q   <= 1'b0;
      wdck_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      bck_q   <= bck_d;
      wdck_q  <= wdck_d;
    end
  end

  assign bck_o  = bck_q;
  assign wdck_o = wdck_q;

  assert_bck_in_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bck_q |-> wdck_q);

  assert_wdck_after_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdck_q) |-> $past(bck_q));

  assert_ready_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && in_valid) |=> !ready_o);

endmodule

// File: rtl/dac_shift_chan.sv
module dac_shift_chan #(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_new,
  input  logic [WORD_W-1:0] word_in,
  input  logic              load_old,
  input  logic              shift,
  output logic              sd
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] hold_q, hold_d;

  always_comb begin
    if (load_new) begin
      sh_d = word_in;
    end else if (load_old) begin
      sh_d = hold_q;
    end else if (shift) begin
      sh_d = {sh_q[WORD_W-2:0], 1'b0};
    end else begin
      sh_d = sh_q;
    end
    hold_d = load_new ? word_in : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
    end else begin
      sh_q   <= sh_d;
      hold_q <= hold_d;
    end
  end

  assign sd = sh_q[WORD_W-1];

endmodule

// File: rtl/dac_serial_tx.sv
module dac_serial_tx #(
  parameter int unsigned WORD_W      = 18,
  parameter int unsigned MIN_RATIO   = 48,
  parameter int unsigned MAX_RATIO   = 384,
  parameter int unsigned STRICT_STEP = 24,
  localparam int unsigned CNT_W      = $clog2(MAX_RATIO + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  ratio_req,
  input  logic              strict_mode,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  output logic              bck,
  output logic              wdck,
  output logic              sd_left,
  output logic              sd_right,
  output logic              underrun
);
  localparam int unsigned NCH = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic [CNT_W-1:0] ratio_eff;
  logic             take, repeat_evt, shift_en;

  dac_ratio_sel #(
    .CNT_W(CNT_W), .MIN_RATIO(MIN_RATIO), .MAX_RATIO(MAX_RATIO), .STEP(STRICT_STEP)
  ) u_ratio (
    .ratio_req(ratio_req),
    .strict(strict_mode),
    .ratio_eff(ratio_eff)
  );

  dac_frame_timer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk),
    .rst_n(rst_sn),
    .ratio_eff(ratio_eff),
    .in_valid(s_valid),
    .ready_o(s_ready),
    .take_o(take),
    .repeat_o(repeat_evt),
    .shift_o(shift_en),
    .bck_o(bck),
    .wdck_o(wdck)
  );

  logic [NCH-1:0][WORD_W-1:0] chan_words;
  logic [NCH-1:0]             chan_sd;
  assign chan_words[0] = s_left;
  assign chan_words[1] = s_right;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dac_shift_chan #(.WORD_W(WORD_W)) u_chan (
      .clk(clk),
      .rst_n(rst_sn),
      .load_new(take),
      .word_in(chan_words[ch]),
      .load_old(repeat_evt),
      .shift(shift_en),
      .sd(chan_sd[ch])
    );
  end

  assign sd_left  = chan_sd[0];
  assign sd_right = chan_sd[1];

  logic under_q, under_d;
  always_comb under_d = under_q | repeat_evt;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) under_q <= 1'b0;
    else         under_q <= under_d;
  end
  assign underrun = under_q;

  assert_left_stable_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(sd_left) |-> !bck);

  assert_right_stable_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(sd_right) |-> !bck);

  assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    underrun |=> underrun);

endmodule

// File: tb/dac_serial_tx_test.sv
module dac_serial_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  ratio_req = 9'd64;
  logic        strict_mode = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [17:0] s_left = '0;
  logic [17:0] s_right = '0;
  logic        bck, wdck, sd_left, sd_right, underrun;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  dac_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .ratio_req(ratio_req), .strict_mode(strict_mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .bck(bck), .wdck(wdck), .sd_left(sd_left), .sd_right(sd_right), .underrun(underrun)
  );

  // port monitor, samples on the falling clock edge
  logic        prev_bck = 1'b0, prev_wd = 1'b1;
  logic [17:0] shl = '0, shr = '0;
  int          pulses = 0, cyc = 0, hi = 0, nframes = 0;
  logic [17:0] cap_l = '0, cap_r = '0;
  int          cap_pulses = 0, cap_period = 0, cap_high = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (wdck) hi = hi + 1;
    if (bck && !prev_bck) begin
      shl = {shl[16:0], sd_left};
      shr = {shr[16:0], sd_right};
      pulses = pulses + 1;
    end
    if (!wdck && prev_wd) begin
      cap_l = shl; cap_r = shr; cap_pulses = pulses;
      cap_period = cyc; cap_high = hi;
      pulses = 0; cyc = 0; hi = 0;
      nframes = nframes + 1;
    end
    prev_bck = bck;
    prev_wd  = wdck;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_pair(input logic [17:0] l, input logic [17:0] r);
    @(negedge clk);
    s_left = l; s_right = r; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1 s_valid = 1'b0;
  endtask

  task automatic wait_frame();
    int c = nframes;
    int guard = 0;
    while (nframes == c && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) chk("frame timeout", 32'd1, 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 bck", 32'(bck), 32'd0);
    chk("R1 wdck", 32'(wdck), 32'd1);
    chk("R1 sd_left", 32'(sd_left), 32'd0);
    chk("R1 sd_right", 32'(sd_right), 32'd0);
    chk("R1 underrun", 32'(underrun), 32'd0);
    chk("R1 s_ready", 32'(s_ready), 32'd1);
  endtask

  task automatic t_idle();
    #1 rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk("R2 wdck idle", 32'(wdck), 32'd1);
    chk("R2 bck idle", 32'(bck), 32'd0);
    chk("R2 data idle", 32'({sd_left, sd_right}), 32'd0);
    chk("R2 no frames", 32'(nframes), 32'd0);
  endtask

  task automatic t_basic();
    ratio_req = 9'd64; strict_mode = 1'b0;
    send_pair(18'h2AAAA, 18'h15555);
    send_pair(18'h3C0F1, 18'h0F0E3);
    wait_frame();
    chk("R4 left word", 32'(cap_l), 32'h3C0F1);
    chk("R5 right word", 32'(cap_r), 32'h0F0E3);
    chk("R3 pulse count", 32'(cap_pulses), 32'd18);
    chk("R6 wdck high time", 32'(cap_high), 32'd36);
    chk("R7 period 64", 32'(cap_period), 32'd64);
    chk("R11 no underrun when fed", 32'(underrun), 32'd0);
  endtask

  task automatic t_patterns(input logic [17:0] l, input logic [17:0] r);
    send_pair(l, r);
    wait_frame();
    chk("R4 msb-first left", 32'(cap_l), 32'(l));
    chk("R5 right channel", 32'(cap_r), 32'(r));
  endtask

  task automatic t_period(input logic [8:0] req, input logic strict, input int exp, input string tag);
    ratio_req = req; strict_mode = strict;
    send_pair(18'h00011, 18'h00022);
    send_pair(18'h00033, 18'h00044);
    send_pair(18'h00055, 18'h00066);
    wait_frame();
    chk(tag, 32'(cap_period), 32'(exp));
    chk("R3 pulses at ratio", 32'(cap_pulses), 32'd18);
  endtask

  task automatic t_midchange();
    ratio_req = 9'd64; strict_mode = 1'b0;
    send_pair(18'h00101, 18'h00202);
    send_pair(18'h00303, 18'h00404);
    repeat (10) @(negedge clk);
    ratio_req = 9'd200;
    send_pair(18'h00505, 18'h00606);
    wait_frame();
    chk("R9 old ratio kept", 32'(cap_period), 32'd64);
    send_pair(18'h00707, 18'h00808);
    wait_frame();
    chk("R9 new ratio next period", 32'(cap_period), 32'd200);
  endtask

  task automatic t_ready();
    int n = 0;
    ratio_req = 9'd64; strict_mode = 1'b0;
    send_pair(18'h00909, 18'h00A0A);
    @(negedge clk);
    chk("R10 ready low after take", 32'(s_ready), 32'd0);
    while (!s_ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 ready in last cycle", 32'(n), 32'd63);
  endtask

  task automatic t_underrun();
    ratio_req = 9'd64; strict_mode = 1'b0;
    send_pair(18'h12345, 18'h2ABCD);
    wait_frame();
    chk("R11 sent word", 32'(cap_l), 32'h12345);
    wait_frame();
    chk("R11 resent left", 32'(cap_l), 32'h12345);
    chk("R11 resent right", 32'(cap_r), 32'h2ABCD);
    chk("R11 flag set", 32'(underrun), 32'd1);
    repeat (200) @(negedge clk);
    chk("R11 flag sticky", 32'(underrun), 32'd1);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_basic();
    t_patterns(18'h20000, 18'h1FFFF);
    t_patterns(18'h00001, 18'h3FFFE);
    t_period(9'd20, 1'b0, 48, "R7 clamp low");
    t_period(9'd500, 1'b0, 384, "R7 clamp high");
    t_period(9'd100, 1'b0, 100, "R7 no rounding");
    t_period(9'd100, 1'b1, 96, "R8 strict 100");
    t_period(9'd383, 1'b1, 360, "R8 strict 383");
    t_period(9'd30, 1'b1, 48, "R8 strict 30");
    t_midchange();
    t_ready();
    t_underrun();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule